// File: doc/BRIEF.md
# Oversampled Multi-Source Edge Capture Register

This block keeps one output bit that is allowed to change only when one of three unrelated, asynchronous strobe signals rises. Each strobe comes with its own data bit. The strobes are never used as clocks. A single fast system clock samples everything. Each strobe goes through a two-flop synchronizer and then a rising-edge detector. The detected edge loads the paired data bit, which has passed through a synchronizer of the same depth, into the output register.

If edges on several sources are recognized in the same system cycle, a fixed priority picks the winner. A per-source edge-valid pulse reports every recognized edge, including those that lose priority. The system clock must run several times faster than any strobe. For example, strobes of up to 20 MHz call for sampling at roughly 80 to 100 MHz. The output trails the real edge by the synchronizer latency, and this delay is expected.

Top module: `edge_capture_reg`

## Requirements
- R1: When a rising edge is recognized on a single source, `q_out` takes that source's data bit.
- R2: Bit 0 of `src_strobe`/`src_data` is source 1, bit 1 is source 2, and bit 2 is source 3. When several sources are recognized in the same cycle, the lowest bit index wins.
- R3: In every cycle with no recognized edge, `q_out` keeps its value, even while the data inputs change.
- R4: A falling edge, or a strobe that stays high, never loads `q_out` and raises no `edge_valid` bit.
- R5: Suppose a strobe rise is first sampled by clock edge k. Then `q_out` and `edge_valid` change at clock edge k+2 and stay unchanged at edge k+1.
- R6: `edge_valid[i]` is a single-cycle pulse, asserted in the same cycle as the update. It is set for every source recognized in that cycle, including sources that lose priority.
- R7: The synchronous active-high `rst` clears `q_out`, `edge_valid` and all synchronizer and history flops to 0.
- R8: A strobe held high across the release of reset produces no edge and leaves `q_out` at 0.
- R9: The captured bit is the data value sampled by the same clock edge that first sampled the strobe high. Later data changes are not captured.
- R10: Edges on different sources spaced three system cycles apart are all recognized, in order, each with its own data bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| src_strobe | input | SRC_N | Asynchronous edge sources, bit 0 = highest priority |
| src_data | input | SRC_N | Data bit paired with each source |
| edge_valid | output | SRC_N | One-cycle pulse per recognized source edge |
| q_out | output | 1 | Held output bit |

## Verification
The hardest case to reach from the ports is two or three strobes rising so that their edges are recognized in the same system cycle. The bench produces this case by changing every selected strobe at the same falling clock edge, so all of them enter their synchronizers together. It sweeps every non-empty source mask against every data pattern. In each run it flips the data one cycle after the strobe is sampled, which shows that the captured bit is the one aligned with the strobe. A strobe held high across the release of reset covers the start-up case.

// File: rtl/edge_capture_pkg.sv
package edge_capture_pkg;

    localparam int SRC_COUNT  = 3;
    localparam int SYNC_DEPTH = 2;

    typedef struct packed {
        logic load;
        logic value;
    } capture_t;

    // Cycles after reset before detection is armed: synchronizer depth plus history flop.
    function automatic int settle_cycles(input int depth);
        return depth + 1;
    endfunction

endpackage

// File: rtl/ecr_sync_chain.sv
module ecr_sync_chain #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage[0] <= '0;
                else     stage[0] <= din;
            end
        end else begin : g_rest
            always_ff @(posedge clk) begin
                if (rst) stage[s] <= '0;
                else     stage[s] <= stage[s-1];
            end
        end
    end

    assign dout = stage[STAGES-1];
endmodule

// File: rtl/ecr_edge_detect.sv
module ecr_edge_detect #(
    parameter int WIDTH  = 3,
    parameter int SETTLE = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] rise
);
    localparam int CW = $clog2(SETTLE + 1);

    logic [WIDTH-1:0] hist;
    logic [CW-1:0]    settle_cnt;
    logic             armed;

    assign armed = (settle_cnt == CW'(SETTLE));

    always_ff @(posedge clk) begin
        if (rst) begin
            hist       <= '0;
            settle_cnt <= '0;
        end else begin
            hist <= level;
            if (!armed) settle_cnt <= settle_cnt + CW'(1);
        end
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_rise
        assign rise[i] = level[i] & ~hist[i] & armed;
    end
endmodule

// File: rtl/ecr_priority_sel.sv
module ecr_priority_sel
    import edge_capture_pkg::*;
#(
    parameter int WIDTH = 3
) (
    input  logic [WIDTH-1:0] hits,
    input  logic [WIDTH-1:0] bits,
    output capture_t         pick
);
    always_comb begin
        pick.load  = 1'b0;
        pick.value = 1'b0;
        // Walk from lowest priority up so the lowest index overrides.
        for (int i = WIDTH - 1; i >= 0; i--) begin
            if (hits[i]) begin
                pick.load  = 1'b1;
                pick.value = bits[i];
            end
        end
    end
endmodule

// File: rtl/edge_capture_reg.sv
module edge_capture_reg
    import edge_capture_pkg::*;
#(
    parameter int SRC_N       = SRC_COUNT,
    parameter int SYNC_STAGES = SYNC_DEPTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SRC_N-1:0] src_strobe,
    input  logic [SRC_N-1:0] src_data,
    output logic [SRC_N-1:0] edge_valid,
    output logic             q_out
);
    localparam int SETTLE = settle_cycles(SYNC_STAGES);

    logic [SRC_N-1:0] strobe_sync;
    logic [SRC_N-1:0] data_sync;
    logic [SRC_N-1:0] edge_hit;
    capture_t         pick;

    ecr_sync_chain #(.WIDTH(SRC_N), .STAGES(SYNC_STAGES)) u_strobe_sync (
        .clk (clk),
        .rst (rst),
        .din (src_strobe),
        .dout(strobe_sync)
    );

    ecr_sync_chain #(.WIDTH(SRC_N), .STAGES(SYNC_STAGES)) u_data_sync (
        .clk (clk),
        .rst (rst),
        .din (src_data),
        .dout(data_sync)
    );

    ecr_edge_detect #(.WIDTH(SRC_N), .SETTLE(SETTLE)) u_detect (
        .clk  (clk),
        .rst  (rst),
        .level(strobe_sync),
        .rise (edge_hit)
    );

    ecr_priority_sel #(.WIDTH(SRC_N)) u_select (
        .hits(edge_hit),
        .bits(data_sync),
        .pick(pick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            edge_valid <= '0;
            q_out      <= 1'b0;
        end else begin
            edge_valid <= edge_hit;
            if (pick.load) q_out <= pick.value;
        end
    end
endmodule

// File: rtl/edge_capture_reg_checker.sv
module edge_capture_reg_checker #(
    parameter int N = 3
) (
    input logic         clk,
    input logic         rst,
    input logic [N-1:0] hit,
    input logic [N-1:0] dsync,
    input logic [N-1:0] edge_valid,
    input logic         q_out
);
    logic past_ok = 1'b0;
    always_ff @(posedge clk) past_ok <= 1'b1;

    assert_reset_clear_R7: assert property (@(posedge clk)
        (past_ok && $past(rst)) |-> (q_out == 1'b0 && edge_valid == '0));

    assert_load_first_R1: assert property (@(posedge clk) disable iff (rst)
        hit[0] |=> (q_out == $past(dsync[0])));

    for (genvar i = 1; i < N; i++) begin : g_prio
        localparam logic [N-1:0] LOWER = N'((1 << i) - 1);
        assert_priority_R2: assert property (@(posedge clk) disable iff (rst)
            (hit[i] && ((hit & LOWER) == '0)) |=> (q_out == $past(dsync[i])));
    end

    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (past_ok && hit == '0) |=> $stable(q_out));

    for (genvar i = 0; i < N; i++) begin : g_pulse
        assert_single_pulse_R6: assert property (@(posedge clk) disable iff (rst)
            edge_valid[i] |=> !edge_valid[i]);
    end
endmodule

bind edge_capture_reg edge_capture_reg_checker #(.N(SRC_N)) u_checker (
    .clk       (clk),
    .rst       (rst),
    .hit       (edge_hit),
    .dsync     (data_sync),
    .edge_valid(edge_valid),
    .q_out     (q_out)
);

// File: tb/edge_capture_reg_bench.sv
module edge_capture_reg_bench;
    localparam int N = 3;

    logic         clk = 1'b0;
    logic         rst;
    logic [N-1:0] src_strobe;
    logic [N-1:0] src_data;
    logic [N-1:0] edge_valid;
    logic         q_out;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 0;
    logic exp_q;

    always #10 clk = ~clk;

    edge_capture_reg u_edge_capture_reg (
        .clk       (clk),
        .rst       (rst),
        .src_strobe(src_strobe),
        .src_data  (src_data),
        .edge_valid(edge_valid),
        .q_out     (q_out)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [7:0] actual, input logic [7:0] expected);
        checks++;
        if (actual !== expected) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, actual, expected, $time);
        end
    endtask

    function automatic int lowest(input logic [N-1:0] m);
        for (int i = 0; i < N; i++) if (m[i]) return i;
        return 0;
    endfunction

    // Coincident rise of every strobe in mask, data pattern pat.
    task automatic coincident(input logic [N-1:0] mask, input logic [N-1:0] pat);
        src_data   = pat;
        src_strobe = mask;
        tick();
        src_data = ~pat;                              // R9: later data must not be taken
        tick();
        check("R5 valid not yet", 8'(edge_valid), 8'(0));
        check("R5 q not yet", 8'(q_out), 8'(exp_q));
        tick();
        exp_q = pat[lowest(mask)];
        check("R6 valid mask", 8'(edge_valid), 8'(mask));
        if ($countones(mask) > 1) check("R2 priority winner", 8'(q_out), 8'(exp_q));
        else                      check("R1 single load", 8'(q_out), 8'(exp_q));
        tick();
        check("R6 pulse ends", 8'(edge_valid), 8'(0));
        check("R9 aligned data", 8'(q_out), 8'(exp_q));
        src_strobe = '0;
        for (int c = 0; c < 4; c++) begin
            tick();
            check("R4 falling ignored", 8'(edge_valid), 8'(0));
            check("R3 hold", 8'(q_out), 8'(exp_q));
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        src_strobe = '0;
        src_data = '0;
        exp_q = 1'b0;
        repeat (3) tick();
        check("R7 reset q", 8'(q_out), 8'(0));
        check("R7 reset valid", 8'(edge_valid), 8'(0));

        // R8: strobes high across reset release
        src_strobe = '1;
        src_data = '1;
        repeat (2) tick();
        rst = 1'b0;
        for (int c = 0; c < 6; c++) begin
            tick();
            check("R8 no edge after reset", 8'(edge_valid), 8'(0));
            check("R8 q stays 0", 8'(q_out), 8'(0));
        end
        src_strobe = '0;
        for (int c = 0; c < 4; c++) begin
            tick();
            check("R4 fall after reset", 8'(edge_valid), 8'(0));
        end

        // Sweep every source mask against every data pattern
        for (int m = 1; m < (1 << N); m++)
            for (int p = 0; p < (1 << N); p++)
                coincident(N'(m), N'(p));

        // R3: data churn with no strobe
        for (int c = 0; c < 8; c++) begin
            src_data = N'(c);
            tick();
            check("R3 data churn hold", 8'(q_out), 8'(exp_q));
            check("R3 no valid", 8'(edge_valid), 8'(0));
        end

        // R10: sources spaced three cycles apart
        src_data = 3'b101;
        for (int c = 0; c < 12; c++) begin
            if (c == 0) src_strobe[0] = 1'b1;
            if (c == 3) src_strobe[1] = 1'b1;
            if (c == 6) src_strobe[2] = 1'b1;
            tick();
            if (c == 2) exp_q = 1'b1;
            if (c == 5) exp_q = 1'b0;
            if (c == 8) exp_q = 1'b1;
            check("R10 spaced valid", 8'(edge_valid),
                  (c == 2) ? 8'h1 : (c == 5) ? 8'h2 : (c == 8) ? 8'h4 : 8'h0);
            check("R10 spaced q", 8'(q_out), 8'(exp_q));
        end
        src_strobe = '0;
        repeat (4) tick();

        // R7: reset mid-operation clears a set output
        check("R7 q set before reset", 8'(q_out), 8'(1));
        rst = 1'b1;
        tick();
        check("R7 mid reset q", 8'(q_out), 8'(0));
        check("R7 mid reset valid", 8'(edge_valid), 8'(0));
        rst = 1'b0;
        exp_q = 1'b0;
        repeat (5) tick();
        coincident(3'b010, 3'b010);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule